// File: doc/BRIEF.md
# Polled Byte-Wide SPI Master for a Configuration Flash

This block gives a host a fast way to talk to a serial configuration flash without toggling every serial bit itself. The host sees two registers on a small bus with write, read, address and data signals. One is a control/status register holding a chip-select bit, which only software drives, and a data-available flag. The other is a data register. A write to the data register sends one byte and receives one byte at the same time. The serial clock runs at one third of the bus clock. When all eight bits have crossed, the data-available flag rises and the host reads back the received byte.

Flash commands, addresses, erase and programming are all left to software. A command of N bytes is made of N write/poll/read rounds, all inside one chip-select window that the host opens and closes through the control register. The serial side uses mode 0 with the most significant bit first. The clock idles low, and each serial period has one low bus cycle followed by two high bus cycles.

Top module: `spib_master`

## Requirements
- R1: After reset, the chip-select output `spi_cs_n` is 1, `spi_sclk` is 0, the control register reads 0x02 (data-available set, chip-select clear) and the data register reads 0x00.
- R2: `spi_cs_n` equals the inverse of control bit 0 (offset 0x70). It changes only on a control-register write, and it stays put while bytes are being shifted.
- R3: A write to the data register (offset 0x74) while idle starts one 8-bit full-duplex transfer, and the data-available flag reads 0 from the next clock onward.
- R4: During a transfer `spi_sclk` gives exactly 8 pulses. Successive rising edges are 3 clocks apart, each pulse is high for 2 clocks, and the clock is 0 whenever no transfer is running.
- R5: `spi_mosi` carries the written byte most significant bit first. It changes only on a falling serial-clock edge or at the start of a transfer.
- R6: `spi_miso` is sampled on each rising serial-clock edge, shifting in from bit 0. After completion the data register returns the received byte in bits 7:0.
- R7: The data-available flag (control bit 1) sets on the 24th clock edge after the edge that accepts the data write. A read presented at an edge updates `bus_rdata` at that edge.
- R8: A data-register write while a transfer is in progress is ignored. The outgoing byte, the received byte and the completion time are unchanged.
- R9: Control bit 1 is read-only, so writing it has no effect on the data-available flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select, software owned |

## Verification
Each result has a known due time. The cleared flag shows in the first read after the accepting edge. The set flag appears in the read whose edge is the 25th after the accepting one, because the flag sets on edge 24 and the read register adds one more. Each serial rising edge is 3 clocks after the previous one. The bench samples every output on the falling clock edge. It polls the control register every cycle and compares the cycle of the first set flag with that arithmetic count. It also measures the serial clock edge by edge, and it checks the shifted-out and shifted-in bytes for all 256 outgoing values, with the flash reply computed from each value.

// File: rtl/spib_pkg.sv
package spib_pkg;
  // control/status bit positions (visible to the host)
  localparam int CS_BIT  = 0;
  localparam int DAV_BIT = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  // status word in its low bits
  function automatic logic [1:0] status_bits(logic cs_on, logic dav_on);
    logic [1:0] s;
    s = '0;
    s[CS_BIT]  = cs_on;
    s[DAV_BIT] = dav_on;
    return s;
  endfunction

  // total bus cycles of one byte transfer
  function automatic int xfer_cycles(int div, int bits);
    return div * bits;
  endfunction
endpackage

// File: rtl/spib_phase.sv
module spib_phase #(
  parameter int DIV = 3,
  parameter int LOW = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(LOW - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(LOW);

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (!rst_n)        ph <= '0;
    else if (restart)  ph <= '0;
    else if (run)      ph <= (ph == PH_LAST) ? '0 : ph + PH_W'(1);
  end

  // sclk high once the low part of the period is over
  assign sclk     = run && (ph >= PH_HIGH);
  // event flags name the clock edge that ends this cycle
  assign rise_evt = run && (ph == PH_RISE);
  assign fall_evt = run && (ph == PH_LAST);
endmodule

// File: rtl/spib_shifter.sv
module spib_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] load,
  input  logic            rise_evt,
  input  logic            fall_evt,
  input  logic            miso,
  output logic            busy,
  output logic            done_evt,
  output logic            mosi,
  output logic [BITS-1:0] rx_byte
);
  localparam int CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  logic [CNT_W-1:0] bcnt;
  logic [BITS-1:0]  tx_sr;
  logic             last_bit;

  assign last_bit = (bcnt == LAST);
  assign done_evt = busy && fall_evt && last_bit;
  assign mosi     = busy && tx_sr[BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bcnt    <= '0;
      tx_sr   <= '0;
      rx_byte <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      bcnt  <= '0;
      tx_sr <= load;
    end else if (busy) begin
      if (rise_evt) rx_byte <= {rx_byte[BITS-2:0], miso};
      if (fall_evt) begin
        tx_sr <= {tx_sr[BITS-2:0], 1'b0};
        if (last_bit) busy <= 1'b0;
        else          bcnt <= bcnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spib_regs.sv
module spib_regs
  import spib_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 8,
  parameter int BITS   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              busy,
  input  logic              done_evt,
  input  logic [BITS-1:0]   rx_byte,
  output logic              start_evt,
  output logic              ctrl_wr_evt,
  output logic              data_wr_evt,
  output logic              cs_active,
  output logic              dav,
  output logic [BITS-1:0]   tx_byte,
  output logic [BUS_W-1:0]  bus_rdata
);
  reg_sel_e sel;

  always_comb begin
    if (bus_addr == CTRL_OFS)      sel = SEL_CTRL;
    else if (bus_addr == DATA_OFS) sel = SEL_DATA;
    else                           sel = SEL_NONE;
  end

  assign ctrl_wr_evt = bus_wr && (sel == SEL_CTRL);
  assign data_wr_evt = bus_wr && (sel == SEL_DATA);
  assign start_evt   = data_wr_evt && !busy;
  assign tx_byte     = bus_wdata[BITS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_active <= 1'b0;
      dav       <= 1'b1;
      bus_rdata <= '0;
    end else begin
      if (ctrl_wr_evt) cs_active <= bus_wdata[CS_BIT];
      if (start_evt)      dav <= 1'b0;
      else if (done_evt)  dav <= 1'b1;
      if (bus_rd) begin
        unique case (sel)
          SEL_CTRL: bus_rdata <= BUS_W'(status_bits(cs_active, dav));
          SEL_DATA: bus_rdata <= BUS_W'(rx_byte);
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spib_master.sv
module spib_master
  import spib_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 8,
  parameter int BITS   = 8,
  parameter int DIV    = 3,
  parameter int LOW    = 1,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  localparam int XFER_CYC = xfer_cycles(DIV, BITS);

  // named internal events, also used by the bound checker
  logic            busy;
  logic            dav;
  logic            cs_active;
  logic            start_evt;
  logic            done_evt;
  logic            rise_evt;
  logic            fall_evt;
  logic            ctrl_wr_evt;
  logic            data_wr_evt;
  logic [BITS-1:0] tx_byte;
  logic [BITS-1:0] rx_byte;

  spib_regs #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .BITS(BITS),
    .CTRL_OFS(CTRL_OFS), .DATA_OFS(DATA_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .done_evt(done_evt), .rx_byte(rx_byte),
    .start_evt(start_evt), .ctrl_wr_evt(ctrl_wr_evt), .data_wr_evt(data_wr_evt),
    .cs_active(cs_active), .dav(dav), .tx_byte(tx_byte), .bus_rdata(bus_rdata)
  );

  spib_phase #(.DIV(DIV), .LOW(LOW)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(start_evt),
    .sclk(spi_sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  spib_shifter #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .load(tx_byte),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .miso(spi_miso),
    .busy(busy), .done_evt(done_evt), .mosi(spi_mosi), .rx_byte(rx_byte)
  );

  assign spi_cs_n = !cs_active;

  initial begin
    if (XFER_CYC < 2 || LOW < 1 || LOW >= DIV || BUS_W < BITS)
      $display("spib_master: unsupported parameter set");
  end
endmodule

// File: rtl/spib_master_chk.sv
module spib_master_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n,
  input logic busy,
  input logic dav,
  input logic start_evt,
  input logic done_evt,
  input logic ctrl_wr_evt,
  input logic data_wr_evt
);
  // R2
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_evt |=> $stable(spi_cs_n));

  // R3
  dav_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!dav && busy));

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk);

  // R4
  sclk_high_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |=> spi_sclk);

  // R4
  sclk_low_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_sclk) && busy) |=> spi_sclk);

  // R5
  mosi_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(spi_sclk)) |-> $stable(spi_mosi));

  // R7
  dav_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (dav && !busy));

  // R8
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_evt && busy) |-> !start_evt);
endmodule

bind spib_master spib_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .busy(busy), .dav(dav), .start_evt(start_evt),
  .done_evt(done_evt), .ctrl_wr_evt(ctrl_wr_evt), .data_wr_evt(data_wr_evt)
);

// File: tb/spib_master_test.sv
module spib_master_test;
  localparam logic [7:0] CTRL_A = 8'h70;
  localparam logic [7:0] DATA_A = 8'h74;
  localparam int DAV_POLL = 3 * 8 + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sclk, spi_mosi, spi_cs_n, spi_miso;

  int errors = 0;
  int checks = 0;

  // flash model and serial monitor state
  logic [7:0] slv_sr = '0;
  logic [7:0] mosi_cap = '0;
  logic       sclk_q = 1'b0;
  int cyc = 0, last_rise = 0, rises = 0, hi_run = 0, per_err = 0, hi_err = 0;

  always #2 clk = ~clk;

  spib_master uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  assign spi_miso = slv_sr[7];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (spi_sclk && !sclk_q) begin
      rises = rises + 1;
      if (rises > 1 && (cyc - last_rise) != 3) per_err = per_err + 1;
      last_rise = cyc;
      mosi_cap  = {mosi_cap[6:0], spi_mosi};
      hi_run    = 0;
    end
    if (spi_sclk) hi_run = hi_run + 1;
    if (!spi_sclk && sclk_q) begin
      if (hi_run != 2) hi_err = hi_err + 1;
      slv_sr = {slv_sr[6:0], 1'b0};
    end
    sclk_q = spi_sclk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // one byte round: write, poll every cycle, read back
  task automatic xfer(input logic [7:0] tx, input logic [7:0] resp,
                      input bit intrude, input logic exp_cs_n);
    int lat;
    logic [7:0] rd;
    lat = 0;
    @(negedge clk);
    rises = 0; per_err = 0; hi_err = 0; slv_sr = resp;
    bus_wr = 1'b1; bus_addr = DATA_A; bus_wdata = tx;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = CTRL_A;
    for (int k = 1; k <= 60 && lat == 0; k++) begin
      @(negedge clk);
      if (k == 1) check("R3 dav cleared", int'(bus_rdata[1]), 0);
      if (bus_rdata[1] && lat == 0) lat = k;
      if (intrude && k == 5) begin
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = DATA_A; bus_wdata = ~tx;
      end
      if (intrude && k == 6) begin
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = CTRL_A;
      end
    end
    bus_addr = DATA_A;
    @(negedge clk);
    bus_rd = 1'b0;
    rd = bus_rdata;
    check(intrude ? "R8 latency kept" : "R7 dav latency", lat, DAV_POLL);
    check(intrude ? "R8 rx kept" : "R6 rx byte", int'(rd), int'(resp));
    check(intrude ? "R8 tx kept" : "R5 mosi msb first", int'(mosi_cap), int'(tx));
    check("R4 pulse count", rises, 8);
    check("R4 rise spacing", per_err, 0);
    check("R4 high width", hi_err, 0);
    check("R2 cs held", int'(spi_cs_n), int'(exp_cs_n));
    check("R4 sclk idle", int'(spi_sclk), 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cs_n reset", int'(spi_cs_n), 1);
    check("R1 sclk reset", int'(spi_sclk), 0);
    reg_read(CTRL_A, v);
    check("R1 ctrl reset", int'(v), 8'h02);
    reg_read(DATA_A, v);
    check("R1 data reset", int'(v), 8'h00);

    // byte with chip-select still high
    xfer(8'h3C, 8'hC3, 1'b0, 1'b1);

    reg_write(CTRL_A, 8'h01);
    check("R2 cs asserted", int'(spi_cs_n), 0);
    reg_read(CTRL_A, v);
    check("R9 ctrl readback", int'(v), 8'h03);
    reg_write(CTRL_A, 8'h01);  // bit 1 written as 0
    reg_read(CTRL_A, v);
    check("R9 dav read-only", int'(v), 8'h03);

    for (int t = 0; t < 256; t++) begin
      logic [7:0] tb, rb;
      tb = 8'(t);
      rb = 8'(t * 7 + 3);
      xfer(tb, rb, (t % 16) == 5, 1'b0);
    end

    reg_write(CTRL_A, 8'h00);
    check("R2 cs released", int'(spi_cs_n), 1);
    reg_read(CTRL_A, v);
    check("R9 ctrl after release", int'(v), 8'h02);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule